// File: doc/BRIEF.md
# DDS Tune Command Sequencer

This block turns one tune command for a direct digital synthesis channel into the series of register writes that reprograms that channel over a 16-bit parallel programming bus. A command carries a channel number, a 32-bit frequency tuning word, a 16-bit phase word, a phase mode, a reference time and the current time. The block works out the phase word that must be written so the output phase follows the chosen mode. It then issues six writes, each completed by a ready handshake on the bus.

In continuous mode the phase accumulator keeps running and a per-channel compensation value is added to the phase word. In absolute and tracking modes the accumulator is cleared at the update strobe, and the phase word is corrected for the time between the strobe and the reference time. The corrected word is stored as that channel's compensation, so a later switch to continuous mode carries on without a phase jump. Commands for channels that do not exist are rejected with an error pulse and produce no bus traffic.

Top module: `dds_tune_sequencer`

## Requirements
- R1: `cmd_ready` is the inverse of `busy`, and a command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. For a valid command, `busy` rises after that edge and falls after the edge on which the update-strobe write is acknowledged. `bus_wr` is never high while `busy` is low.
- R2: A valid command produces exactly six writes, in this order of addresses: 0x81 (channel select), 0x2D (tuning word low), 0x2F (tuning word high), 0x01 (phase-control config), 0x31 (phase word), 0x80 (update strobe).
- R3: The select write carries the channel code shifted left by one, with bit 0 at 0. The code is the binary channel number when `ONEHOT_SEL` is 0, and `1 << channel` when it is 1.
- R4: The tuning word goes out as two 16-bit halves: bits 15:0 at 0x2D first, then bits 31:16 at 0x2F.
- R5: Mode 0 (continuous) writes config 0x0008 and phase word = `cmd_pow` + stored compensation of the channel, modulo 2^16. The stored compensation is left unchanged.
- R6: Modes 1 and 3 (absolute) write config 0x2008. With update time U = now + 2·`WRITE_DUR` and D = ref − U as a signed value, the phase word is `cmd_pow` − ((D·`CLK_RATIO`·FTW) >>> 16), modulo 2^16. The shift is arithmetic and the times are unsigned. The result is stored as the channel's compensation.
- R7: Mode 2 (tracking) behaves as R6 and also adds ((ref·`CLK_RATIO`·FTW) >>> 16). The result is stored as the channel's compensation.
- R8: Each write holds `bus_wr`, `bus_addr` and `bus_data` steady until `bus_ack` is high on a clock edge, and exactly one write completes on each such edge.
- R9: A command whose channel number is `CHAN_COUNT` or above issues no write and leaves `busy` low. It raises `cmd_err` for exactly one cycle, just after the accepting edge.
- R10: After reset, `busy`, `bus_wr` and `cmd_err` are low, `cmd_ready` is high, and every channel's compensation is zero.
- R11: The update-strobe write at 0x80 carries data 0x0000.
- R12: The phase arithmetic takes a fixed number of cycles. For a valid command, `bus_wr` first goes high after the fourth clock edge following the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_chan | input | CMD_CH_W | Target channel number |
| cmd_mode | input | 2 | Phase mode: 0 continuous, 1/3 absolute, 2 tracking |
| cmd_ftw | input | 32 | Frequency tuning word |
| cmd_pow | input | POW_W | Requested phase word |
| cmd_ref_time | input | TIME_W | Phase reference time |
| cmd_now_time | input | TIME_W | Time of the command's first write |
| cmd_err | output | 1 | One-cycle pulse for a rejected channel |
| busy | output | 1 | Command in progress |
| bus_addr | output | 8 | Register address |
| bus_data | output | 16 | Register write data |
| bus_wr | output | 1 | Write request |
| bus_ack | input | 1 | Write accepted by the bus |

## Verification
The bench builds two instances side by side with `CHAN_COUNT` = 6, a 3-bit channel field, `TIME_W` = 24, `CLK_RATIO` = 3 and `WRITE_DUR` = 5. One uses binary select codes and the other one-hot codes. Six channels in a 3-bit field leave channel numbers 6 and 7 free to exercise rejection. The narrow time width keeps every product inside 64-bit bench integers, so the signed corrections for times before and after the update can be checked exactly. The bus acknowledge follows an irregular stall pattern, so the hold behaviour is covered on every write position.

// File: rtl/dds_seq_pkg.sv
// Shared constants and types for the DDS tune sequencer.
// Assumes a 16-bit data / 8-bit address register bus.
package dds_seq_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 16;
    localparam int FTW_W  = 32;

    // Register addresses; the write order below is behaviour.
    localparam logic [BUS_AW-1:0] A_SEL    = 8'h81;
    localparam logic [BUS_AW-1:0] A_FTW_LO = 8'h2D;
    localparam logic [BUS_AW-1:0] A_FTW_HI = 8'h2F;
    localparam logic [BUS_AW-1:0] A_CFG    = 8'h01;
    localparam logic [BUS_AW-1:0] A_POW    = 8'h31;
    localparam logic [BUS_AW-1:0] A_UPD    = 8'h80;

    // Config words: accumulator kept, or cleared at update.
    localparam logic [BUS_DW-1:0] CFG_KEEP  = 16'h0008;
    localparam logic [BUS_DW-1:0] CFG_CLEAR = 16'h2008;

    typedef enum logic [1:0] {
        PM_CONT    = 2'd0,
        PM_ABS     = 2'd1,
        PM_TRACK   = 2'd2,
        PM_ABS_ALT = 2'd3
    } phase_mode_e;

    typedef enum logic [2:0] {
        W_SEL    = 3'd0,
        W_FTW_LO = 3'd1,
        W_FTW_HI = 3'd2,
        W_CFG    = 3'd3,
        W_POW    = 3'd4,
        W_UPD    = 3'd5
    } wr_step_e;
endpackage

// File: rtl/dds_phase_calc.sv
// Three-stage phase word computation.
// Stage 1 forms the signed time differences. Stage 2 forms the products with the
// clock ratio and the tuning word. Stage 3 applies mode selection and truncates
// the result to POW_W bits. Assumes the inputs stay steady only in the start cycle.
module dds_phase_calc
    import dds_seq_pkg::*;
#(
    parameter int TIME_W    = 48,
    parameter int POW_W     = 16,
    parameter int CLK_RATIO = 8,
    parameter int WRITE_DUR = 40
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  phase_mode_e       mode,
    input  logic [FTW_W-1:0]  ftw,
    input  logic [POW_W-1:0]  pow_in,
    input  logic [TIME_W-1:0] ref_time,
    input  logic [TIME_W-1:0] now_time,
    input  logic [POW_W-1:0]  comp_in,
    output logic              done,
    output logic [POW_W-1:0]  pow_out
);
    localparam int DELTA_W = TIME_W + 2;
    localparam int RATIO_W = $clog2(CLK_RATIO + 1) + 1;
    localparam int PROD_W  = DELTA_W + RATIO_W + FTW_W + 2;
    localparam int SH      = FTW_W - POW_W;
    localparam logic signed [PROD_W-1:0]  RATIO_X = PROD_W'(CLK_RATIO);
    localparam logic signed [DELTA_W-1:0] UPD_OFS = DELTA_W'(2 * WRITE_DUR);

    logic                      s1_v, s2_v;
    phase_mode_e               s1_mode, s2_mode;
    logic [FTW_W-1:0]          s1_ftw;
    logic [POW_W-1:0]          s1_pow, s2_pow, s1_comp, s2_comp;
    logic signed [DELTA_W-1:0] s1_delta, s1_ref;
    logic [POW_W-1:0]          s2_dterm, s2_rterm;
    logic signed [PROD_W-1:0]  dprod, rprod;
    logic                      unused_prod_bits;

    // Products of the stage-1 values, all taken at full width.
    always_comb begin
        dprod = PROD_W'(s1_delta) * RATIO_X * PROD_W'($signed({1'b0, s1_ftw}));
        rprod = PROD_W'(s1_ref)   * RATIO_X * PROD_W'($signed({1'b0, s1_ftw}));
    end
    assign unused_prod_bits = ^{dprod[PROD_W-1:SH+POW_W], dprod[SH-1:0],
                                rprod[PROD_W-1:SH+POW_W], rprod[SH-1:0]};

    // Valid bits of the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            done <= 1'b0;
        end else begin
            s1_v <= start;
            s2_v <= s1_v;
            done <= s2_v;
        end
    end

    // Stage 1: capture the operands and form the signed time differences.
    always_ff @(posedge clk) begin
        if (start) begin
            s1_mode  <= mode;
            s1_ftw   <= ftw;
            s1_pow   <= pow_in;
            s1_comp  <= comp_in;
            s1_delta <= $signed({2'b00, ref_time}) - $signed({2'b00, now_time}) - UPD_OFS;
            s1_ref   <= $signed({2'b00, ref_time});
        end
    end

    // Stage 2: keep the bits of each shifted product that survive truncation.
    always_ff @(posedge clk) begin
        if (s1_v) begin
            s2_mode  <= s1_mode;
            s2_pow   <= s1_pow;
            s2_comp  <= s1_comp;
            s2_dterm <= dprod[SH +: POW_W];
            s2_rterm <= rprod[SH +: POW_W];
        end
    end

    // Stage 3: combine the terms according to the phase mode.
    always_ff @(posedge clk) begin
        if (s2_v) begin
            case (s2_mode)
                PM_CONT:  pow_out <= s2_pow + s2_comp;
                PM_TRACK: pow_out <= s2_pow - s2_dterm + s2_rterm;
                default:  pow_out <= s2_pow - s2_dterm;
            endcase
        end
    end

    // R12: the result appears a fixed three cycles after start.
    p_fixed_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##3 done);
endmodule

// File: rtl/dds_comp_store.sv
// Per-channel phase compensation registers.
// Each register resets to zero and is loaded only when its own channel is written.
// Assumes the writer never addresses a channel at or above CHAN_COUNT.
module dds_comp_store #(
    parameter int CHAN_COUNT = 8,
    parameter int IDX_W      = 3,
    parameter int POW_W      = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_ch,
    output logic [POW_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_ch,
    input  logic [POW_W-1:0] wr_data
);
    logic [POW_W-1:0] comp_q [CHAN_COUNT];

    for (genvar g = 0; g < CHAN_COUNT; g++) begin : g_chan
        // One compensation register, loaded when its channel is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                comp_q[g] <= '0;
            else if (wr_en && (int'(wr_ch) == g))
                comp_q[g] <= wr_data;
        end
    end

    // Read multiplexer; channel numbers out of range read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < CHAN_COUNT; i++)
            if (int'(rd_ch) == i) rd_data = comp_q[i];
    end

    // R9: rejected channels never reach the compensation store.
    p_wr_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_ch) < CHAN_COUNT));
endmodule

// File: rtl/dds_bus_sequencer.sv
// Issues the six register writes of one tune command in a fixed order.
// Each write is held until bus_ack and then advances. done pulses with the strobe acknowledge.
// Assumes the word inputs stay steady from start to done.
module dds_bus_sequencer
    import dds_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUS_DW-1:0] sel_word,
    input  logic [FTW_W-1:0]  ftw,
    input  logic [BUS_DW-1:0] cfg_word,
    input  logic [BUS_DW-1:0] pow_word,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_data,
    output logic              bus_wr,
    input  logic              bus_ack,
    output logic              done
);
    wr_step_e step;

    // Address and data of the current step.
    always_comb begin
        case (step)
            W_SEL:    begin bus_addr = A_SEL;    bus_data = sel_word;          end
            W_FTW_LO: begin bus_addr = A_FTW_LO; bus_data = ftw[15:0];         end
            W_FTW_HI: begin bus_addr = A_FTW_HI; bus_data = ftw[31:16];        end
            W_CFG:    begin bus_addr = A_CFG;    bus_data = cfg_word;          end
            W_POW:    begin bus_addr = A_POW;    bus_data = pow_word;          end
            W_UPD:    begin bus_addr = A_UPD;    bus_data = '0;                end
            default:  begin bus_addr = '0;       bus_data = '0;                end
        endcase
    end

    assign done = bus_wr && bus_ack && (step == W_UPD);

    // Step counter and write request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr <= 1'b0;
            step   <= W_SEL;
        end else if (start) begin
            bus_wr <= 1'b1;
            step   <= W_SEL;
        end else if (bus_wr && bus_ack) begin
            if (step == W_UPD)
                bus_wr <= 1'b0;
            else
                step <= wr_step_e'(step + 3'd1);
        end
    end

    // R8: an unacknowledged write is held unchanged.
    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_data)));
    // R2: every sequence begins with the select write.
    p_first_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bus_wr && bus_addr == A_SEL));
    // R4: the low tuning half is followed by the high half.
    p_ftw_halves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ack && bus_addr == A_FTW_LO) |=> (bus_wr && bus_addr == A_FTW_HI));
endmodule

// File: rtl/dds_tune_sequencer.sv
// Top level of the DDS tune sequencer.
// Accepts one command at a time and rejects channels that do not exist. Starts
// the phase pipeline, updates the compensation store for the clearing modes and
// hands the words to the bus sequencer. Assumes POW_W <= 16, and
// CHAN_COUNT <= 15 when one-hot select codes are chosen.
module dds_tune_sequencer
    import dds_seq_pkg::*;
#(
    parameter int CHAN_COUNT = 8,
    parameter int CMD_CH_W   = 4,
    parameter bit ONEHOT_SEL = 1'b0,
    parameter int POW_W      = 16,
    parameter int TIME_W     = 48,
    parameter int CLK_RATIO  = 8,
    parameter int WRITE_DUR  = 40
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [CMD_CH_W-1:0] cmd_chan,
    input  logic [1:0]          cmd_mode,
    input  logic [FTW_W-1:0]    cmd_ftw,
    input  logic [POW_W-1:0]    cmd_pow,
    input  logic [TIME_W-1:0]   cmd_ref_time,
    input  logic [TIME_W-1:0]   cmd_now_time,
    output logic                cmd_err,
    output logic                busy,
    output logic [BUS_AW-1:0]   bus_addr,
    output logic [BUS_DW-1:0]   bus_data,
    output logic                bus_wr,
    input  logic                bus_ack
);
    localparam int IDX_W = (CHAN_COUNT > 1) ? $clog2(CHAN_COUNT) : 1;

    logic              accept, chan_ok, calc_start, calc_done, seq_done;
    logic [IDX_W-1:0]  cap_ch;
    phase_mode_e       cap_mode;
    logic [FTW_W-1:0]  cap_ftw;
    logic [POW_W-1:0]  cap_pow, comp_rd, pow_res;
    logic [TIME_W-1:0] cap_ref, cap_now;
    logic [BUS_DW-1:0] sel_word, cfg_word;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && !busy;
    assign chan_ok   = int'(cmd_chan) < CHAN_COUNT;

    // Command acceptance, rejection pulse and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cmd_err    <= 1'b0;
            calc_start <= 1'b0;
        end else begin
            cmd_err    <= 1'b0;
            calc_start <= 1'b0;
            if (accept) begin
                if (chan_ok) begin
                    busy       <= 1'b1;
                    calc_start <= 1'b1;
                end else begin
                    cmd_err <= 1'b1;
                end
            end else if (seq_done) begin
                busy <= 1'b0;
            end
        end
    end

    // Capture of the accepted command fields.
    always_ff @(posedge clk) begin
        if (accept && chan_ok) begin
            cap_ch   <= IDX_W'(cmd_chan);
            cap_mode <= phase_mode_e'(cmd_mode);
            cap_ftw  <= cmd_ftw;
            cap_pow  <= cmd_pow;
            cap_ref  <= cmd_ref_time;
            cap_now  <= cmd_now_time;
        end
    end

    // Select code: binary or one-hot, always shifted clear of the reset bit.
    if (ONEHOT_SEL) begin : g_sel_onehot
        assign sel_word = BUS_DW'(1) << (int'(cap_ch) + 1);
    end else begin : g_sel_binary
        assign sel_word = BUS_DW'({cap_ch, 1'b0});
    end

    assign cfg_word = (cap_mode == PM_CONT) ? CFG_KEEP : CFG_CLEAR;

    dds_comp_store #(
        .CHAN_COUNT (CHAN_COUNT),
        .IDX_W      (IDX_W),
        .POW_W      (POW_W)
    ) u_comp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_ch   (cap_ch),
        .rd_data (comp_rd),
        .wr_en   (calc_done && (cap_mode != PM_CONT)),
        .wr_ch   (cap_ch),
        .wr_data (pow_res)
    );

    dds_phase_calc #(
        .TIME_W    (TIME_W),
        .POW_W     (POW_W),
        .CLK_RATIO (CLK_RATIO),
        .WRITE_DUR (WRITE_DUR)
    ) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (calc_start),
        .mode     (cap_mode),
        .ftw      (cap_ftw),
        .pow_in   (cap_pow),
        .ref_time (cap_ref),
        .now_time (cap_now),
        .comp_in  (comp_rd),
        .done     (calc_done),
        .pow_out  (pow_res)
    );

    dds_bus_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (calc_done),
        .sel_word (sel_word),
        .ftw      (cap_ftw),
        .cfg_word (cfg_word),
        .pow_word (BUS_DW'(pow_res)),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .bus_wr   (bus_wr),
        .bus_ack  (bus_ack),
        .done     (seq_done)
    );

    // R1: the bus is only driven while a command is in progress.
    p_wr_needs_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> busy);
    // R1: the acknowledged strobe write ends the command.
    p_strobe_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ack && bus_addr == A_UPD) |=> !busy);
    // R9: a rejection leaves the block idle.
    p_reject_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!busy && !bus_wr));
    // R11: the strobe write carries zero data.
    p_strobe_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_UPD) |-> (bus_data == '0));
endmodule

// File: tb/tb_dds_tune_sequencer.sv
// Bench: a behavioural model queues the expected writes of every command, and
// each clock the bus is compared with it. A one-hot twin runs in lockstep.
module tb_dds_tune_sequencer;
    localparam int NCH = 6;
    localparam int TW  = 24;
    localparam int RAT = 3;
    localparam int WD  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_chan = '0;
    logic [1:0] cmd_mode = '0;
    logic [31:0] cmd_ftw = '0;
    logic [15:0] cmd_pow = '0;
    logic [TW-1:0] cmd_ref_time = '0, cmd_now_time = '0;
    logic bus_ack = 1'b0;
    logic cmd_ready, cmd_err, busy, bus_wr;
    logic [7:0] bus_addr;
    logic [15:0] bus_data;
    logic oh_ready, oh_err, oh_busy, oh_wr;
    logic [7:0] oh_addr;
    logic [15:0] oh_data;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0]  a;
        logic [15:0] d;
        logic [15:0] dh;
        string       tag;
    } exp_t;
    exp_t q[$];
    logic [15:0] comp_m [NCH];

    always #5 clk = ~clk;

    dds_tune_sequencer #(.CHAN_COUNT(NCH), .CMD_CH_W(3), .ONEHOT_SEL(1'b0),
        .POW_W(16), .TIME_W(TW), .CLK_RATIO(RAT), .WRITE_DUR(WD)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_chan(cmd_chan), .cmd_mode(cmd_mode), .cmd_ftw(cmd_ftw), .cmd_pow(cmd_pow),
        .cmd_ref_time(cmd_ref_time), .cmd_now_time(cmd_now_time), .cmd_err(cmd_err),
        .busy(busy), .bus_addr(bus_addr), .bus_data(bus_data), .bus_wr(bus_wr),
        .bus_ack(bus_ack));

    dds_tune_sequencer #(.CHAN_COUNT(NCH), .CMD_CH_W(3), .ONEHOT_SEL(1'b1),
        .POW_W(16), .TIME_W(TW), .CLK_RATIO(RAT), .WRITE_DUR(WD)) dut_oh (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(oh_ready),
        .cmd_chan(cmd_chan), .cmd_mode(cmd_mode), .cmd_ftw(cmd_ftw), .cmd_pow(cmd_pow),
        .cmd_ref_time(cmd_ref_time), .cmd_now_time(cmd_now_time), .cmd_err(oh_err),
        .busy(oh_busy), .bus_addr(oh_addr), .bus_data(oh_data), .bus_wr(oh_wr),
        .bus_ack(bus_ack));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference phase word per the mode rules; updates the model compensation.
    function automatic logic [15:0] model_pow(input int ch, input int mode,
            input logic [31:0] ftw, input logic [15:0] pw,
            input logic [TW-1:0] rt, input logic [TW-1:0] nt);
        longint d, p, f, r;
        f = longint'(ftw);
        r = longint'(rt);
        d = r - (longint'(nt) + 2 * WD);
        p = longint'(pw);
        if (mode == 0) begin
            p = p + longint'(comp_m[ch]);
        end else begin
            p = p - ((d * RAT * f) >>> 16);
            if (mode == 2) p = p + ((r * RAT * f) >>> 16);
            comp_m[ch] = p[15:0];
        end
        return p[15:0];
    endfunction

    task automatic send_cmd(input int ch, input int mode, input logic [31:0] ftw,
            input logic [15:0] pw, input logic [TW-1:0] rt, input logic [TW-1:0] nt);
        logic [15:0] pexp;
        string ptag;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_chan = 3'(ch);
        cmd_mode = 2'(mode);
        cmd_ftw = ftw;
        cmd_pow = pw;
        cmd_ref_time = rt;
        cmd_now_time = nt;
        cmd_valid = 1'b1;
        if (ch < NCH) begin
            pexp = model_pow(ch, mode, ftw, pw, rt, nt);
            ptag = (mode == 0) ? "R5" : (mode == 2) ? "R7" : "R6";
            q.push_back('{8'h81, 16'(ch << 1), 16'((1 << ch) << 1), "R3 select"});
            q.push_back('{8'h2D, ftw[15:0], ftw[15:0], "R4 ftw low"});
            q.push_back('{8'h2F, ftw[31:16], ftw[31:16], "R4 ftw high"});
            q.push_back('{8'h01, (mode == 0) ? 16'h0008 : 16'h2008,
                          (mode == 0) ? 16'h0008 : 16'h2008, {ptag, " config"}});
            q.push_back('{8'h31, pexp, pexp, {ptag, " phase word"}});
            q.push_back('{8'h80, 16'h0000, 16'h0000, "R11 strobe"});
        end
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    // Irregular acknowledge pattern, changed away from the edges.
    initial begin
        int k = 0;
        forever begin
            @(posedge clk);
            #2;
            k++;
            bus_ack = ((k % 4) != 2) && ((k % 7) != 3);
        end
    end

    // Per-clock comparison with the model queue.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && !finished) begin
                if (bus_wr && !busy)
                    chk(1'b0, "R1 write while idle", bus_wr, 0);
                if (bus_wr && bus_ack) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R2/R9 unexpected write", bus_addr, 0);
                    end else begin
                        e = q.pop_front();
                        chk(bus_addr == e.a, {e.tag, " R2/R8 address"}, bus_addr, e.a);
                        chk(bus_data == e.d, {e.tag, " data"}, bus_data, e.d);
                        chk(oh_wr && oh_addr == e.a && oh_data == e.dh,
                            {e.tag, " one-hot twin"}, oh_data, e.dh);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1500000;
        if (!finished) begin
            chk(1'b0, "watchdog timeout", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) comp_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(cmd_ready == 1'b1, "R10 ready after reset", cmd_ready, 1);
        chk(busy == 1'b0 && bus_wr == 1'b0, "R10 idle after reset", {busy, bus_wr}, 0);
        chk(cmd_err == 1'b0, "R10 no error after reset", cmd_err, 0);
        rst_n = 1'b1;

        // R12: fixed latency to first write; R10 zero compensation via continuous mode
        send_cmd(1, 0, 32'h1234_5678, 16'h0100, 24'd0, 24'd0);
        for (int n = 1; n <= 5; n++) begin
            @(negedge clk);
            if (n < 5) chk(bus_wr == 1'b0, "R12 no early write", bus_wr, 0);
            else       chk(bus_wr == 1'b1, "R12 first write on fourth edge", bus_wr, 1);
        end

        send_cmd(2, 1, 32'h0100_0000, 16'h4000, 24'd1000, 24'd900);   // R6 positive delta
        send_cmd(2, 0, 32'h0200_0000, 16'h0010, 24'd0, 24'd50);       // R5 uses stored comp
        send_cmd(3, 2, 32'hDEAD_BEEF, 16'h1234, 24'd5000, 24'd6000);  // R7 negative delta
        send_cmd(3, 0, 32'h0000_0001, 16'h0000, 24'd0, 24'd0);        // R5 continuity
        send_cmd(5, 3, 32'hFFFF_FFFF, 16'hFFFF, 24'd200, 24'd10);     // R6 mode 3, top channel

        // R9: rejected channel pulses error for one cycle, no writes
        send_cmd(6, 2, 32'h1111_1111, 16'h2222, 24'd7, 24'd3);
        chk(cmd_err == 1'b1, "R9 error pulse", cmd_err, 1);
        chk(busy == 1'b0, "R9 stays idle", busy, 0);
        @(posedge clk);
        #1 chk(cmd_err == 1'b0, "R9 pulse is one cycle", cmd_err, 0);
        send_cmd(7, 0, 32'h0, 16'h0, 24'd0, 24'd0);
        chk(cmd_err == 1'b1, "R9 error pulse channel 7", cmd_err, 1);

        send_cmd(0, 2, 32'h8000_0001, 16'hABCD, 24'd300000, 24'd299990); // R7 large ref
        send_cmd(0, 0, 32'h0400_0000, 16'h0001, 24'd0, 24'd0);           // R5 after tracking
        send_cmd(4, 1, 32'h0000_FFFF, 16'h0000, 24'd0, 24'd100);         // R6 ref before update

        @(negedge clk);
        while (busy || q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R2 all writes seen", q.size(), 0);
        chk(busy == 1'b0 && cmd_ready == 1'b1, "R1 idle at end", busy, 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule